// File: doc/BRIEF.md
# Global Counter with Compare Channel

This block is a free-running 64-bit up-counter with one 64-bit compare channel. A simple register port drives it: single-cycle writes and combinational reads, 32-bit data. Software preloads the counter one 32-bit half at a time and then sets a run bit. Once running, the counter advances by one every clock cycle.

The compare channel can be armed in two ways. In one-shot mode a single equality between the counter and the compare value raises a match. In periodic mode the hardware adds a programmed increment to the compare value at every match, so the next match is scheduled without software help. A match sets a sticky status bit. That bit, gated by an enable bit, drives a level interrupt, and software clears it by writing one to it.

Every write to a counter half, a compare half, the increment or the control register sets a sticky write-status bit one cycle later. Software uses that bit as confirmation that the write took effect and clears it by writing one. Reads of the counter halves return the live value, so software re-reads the high word to detect a carry between the two reads.

Top module: `glb_timer_top`

## Requirements
- R1: After reset the counter, compare value, increment, control, interrupt status, interrupt enable and both write-status registers all read 0, and `irq` is low.
- R2: While control bit 8 (run) is 1, the counter at 0x100 (low word) / 0x104 (high word) grows by exactly one per clock cycle. While run is 0 it holds its value.
- R3: A write to 0x100 loads the low 32 bits and a write to 0x104 loads the high 32 bits. The other half is kept. In the cycle of the load the load replaces the increment, and counting resumes from the loaded value.
- R4: The carry out of the low word propagates into the high word (0x5_FFFFFFFE advances to 0x6_00000001 after three counts).
- R5: When control bit 0 (compare enable) is 1 and the counter equals the compare value (0x200 low word, 0x204 high word), bit 0 of the status register at 0x244 reads 1 from the next cycle on. With compare enable at 0, equality sets nothing.
- R6: `irq` is high exactly when status bit 0 and bit 0 of the enable register at 0x248 are both 1.
- R7: Writing 1 to bit 0 of 0x244 clears the match status, and writing 0 leaves it unchanged. If a match and a clearing write fall in the same cycle, the status stays set.
- R8: With control bit 1 (auto-increment) set, each match adds the 32-bit increment held at 0x208 to the compare value, so matches recur every increment cycles. A compare write in the same cycle takes precedence over the addition.
- R9: The counter write-status register at 0x110 sets bit 0 one cycle after a low-word counter write and bit 1 one cycle after a high-word counter write. Each bit is cleared by writing 1 to it.
- R10: The global write-status register at 0x24C sets bit 0 after a compare-low write, bit 1 after a compare-high write, bit 2 after an increment write and bit 16 after a control write. Each bit is cleared by writing 1 to it.
- R11: The control register reads back only bits 0, 1 and 8. All other bits read 0.
- R12: Without auto-increment, a match leaves the compare value unchanged, and no further match occurs while the counter moves past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, one write per cycle with it high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: match status AND enable |

## Verification
The bench builds the block with its default parameters: 32-bit data words and a 12-bit address. With the counter split into two 32-bit halves, a preload just below the low-word boundary reaches the carry into the high word within three cycles. Small compare and increment values place one-shot and periodic matches within a dozen cycles of the start write. An increment of one keeps the compare value moving in lockstep with the counter, which makes a match coincide with a clearing write and exposes the set-over-clear priority at the ports.

// File: rtl/glb_timer_pkg.sv
package glb_timer_pkg;

    // Register byte offsets
    localparam logic [11:0] OFF_CNT_LO  = 12'h100;
    localparam logic [11:0] OFF_CNT_HI  = 12'h104;
    localparam logic [11:0] OFF_CWSTAT  = 12'h110;
    localparam logic [11:0] OFF_CMP_LO  = 12'h200;
    localparam logic [11:0] OFF_CMP_HI  = 12'h204;
    localparam logic [11:0] OFF_INCR    = 12'h208;
    localparam logic [11:0] OFF_CTRL    = 12'h240;
    localparam logic [11:0] OFF_ISTAT   = 12'h244;
    localparam logic [11:0] OFF_IENB    = 12'h248;
    localparam logic [11:0] OFF_GWSTAT  = 12'h24C;

    // Bit positions that software relies on
    localparam int BIT_CMP_EN   = 0;
    localparam int BIT_AUTO_INC = 1;
    localparam int BIT_RUN      = 8;
    localparam int GWS_CMP_LO   = 0;
    localparam int GWS_CMP_HI   = 1;
    localparam int GWS_INCR     = 2;
    localparam int GWS_CTRL     = 16;

    // One strobe per writable register
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic incr;
        logic ctrl;
        logic istat;
        logic ienb;
        logic cwstat;
        logic gwstat;
    } wr_strb_t;

    // Write-data bits the control/status logic looks at
    typedef struct packed {
        logic b16;
        logic b8;
        logic b2;
        logic b1;
        logic b0;
    } ctl_bits_t;

endpackage

// File: rtl/glb_timer_counter.sv
module glb_timer_counter
    import glb_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cnt
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // A load of either half replaces the increment in that cycle
    always_comb begin
        st_d = st_q;
        if (ld_lo) begin
            st_d.value[DATA_W-1:0] = wdata;
        end else if (ld_hi) begin
            st_d.value[CNT_W-1:DATA_W] = wdata;
        end else if (run) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.value;

endmodule

// File: rtl/glb_timer_cmp.sv
module glb_timer_cmp
    import glb_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   cnt,
    input  logic                  cmp_en,
    input  logic                  auto_inc,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_incr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cmp,
    output logic [DATA_W-1:0]     incr,
    output logic                  match
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [DATA_W-1:0] incr;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    assign match = cmp_en && (cnt == st_q.cmp);

    // Software writes to the compare value take precedence over re-arming
    always_comb begin
        st_d = st_q;
        if (wr_incr) st_d.incr = wdata;
        if (wr_lo) begin
            st_d.cmp[DATA_W-1:0] = wdata;
        end else if (wr_hi) begin
            st_d.cmp[CNT_W-1:DATA_W] = wdata;
        end else if (match && auto_inc) begin
            st_d.cmp = st_q.cmp + {{DATA_W{1'b0}}, st_q.incr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp  = st_q.cmp;
    assign incr = st_q.incr;

endmodule

// File: rtl/glb_timer_regs.sv
module glb_timer_regs
    import glb_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wr_strb_t  strb,
    input  ctl_bits_t wbits,
    input  logic      match,
    output logic      run,
    output logic      cmp_en,
    output logic      auto_inc,
    output logic      istat,
    output logic      ien,
    output logic [1:0] cws,
    output logic [3:0] gws,
    output logic      irq
);
    typedef struct packed {
        logic       run;
        logic       cmp_en;
        logic       auto_inc;
        logic       istat;
        logic       ien;
        logic [1:0] cws;
        logic [3:0] gws;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [1:0] cws_set, cws_clr;
    logic [3:0] gws_set, gws_clr;

    assign cws_set = {strb.cnt_hi, strb.cnt_lo};
    assign cws_clr = {2{strb.cwstat}} & {wbits.b1, wbits.b0};
    assign gws_set = {strb.ctrl, strb.incr, strb.cmp_hi, strb.cmp_lo};
    assign gws_clr = {4{strb.gwstat}} & {wbits.b16, wbits.b2, wbits.b1, wbits.b0};

    // Every sticky bit: a set in the same cycle beats a write-one clear
    always_comb begin
        st_d = st_q;
        if (strb.ctrl) begin
            st_d.run      = wbits.b8;
            st_d.cmp_en   = wbits.b0;
            st_d.auto_inc = wbits.b1;
        end
        if (strb.ienb) st_d.ien = wbits.b0;
        st_d.istat = (st_q.istat && !(strb.istat && wbits.b0)) || match;
        for (int i = 0; i < 2; i++) begin
            st_d.cws[i] = (st_q.cws[i] && !cws_clr[i]) || cws_set[i];
        end
        for (int i = 0; i < 4; i++) begin
            st_d.gws[i] = (st_q.gws[i] && !gws_clr[i]) || gws_set[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.run;
    assign cmp_en   = st_q.cmp_en;
    assign auto_inc = st_q.auto_inc;
    assign istat    = st_q.istat;
    assign ien      = st_q.ien;
    assign cws      = st_q.cws;
    assign gws      = st_q.gws;
    assign irq      = st_q.istat && st_q.ien;

endmodule

// File: rtl/glb_timer_top.sv
module glb_timer_top
    import glb_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    wr_strb_t          strb;
    ctl_bits_t         wbits;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [DATA_W-1:0] incr;
    logic              match;
    logic              run, cmp_en, auto_inc, istat, ien;
    logic [1:0]        cws;
    logic [3:0]        gws;

    // Address decode into one-hot write strobes
    always_comb begin
        strb        = '0;
        strb.cnt_lo = bus_wen && (bus_addr == ADDR_W'(OFF_CNT_LO));
        strb.cnt_hi = bus_wen && (bus_addr == ADDR_W'(OFF_CNT_HI));
        strb.cmp_lo = bus_wen && (bus_addr == ADDR_W'(OFF_CMP_LO));
        strb.cmp_hi = bus_wen && (bus_addr == ADDR_W'(OFF_CMP_HI));
        strb.incr   = bus_wen && (bus_addr == ADDR_W'(OFF_INCR));
        strb.ctrl   = bus_wen && (bus_addr == ADDR_W'(OFF_CTRL));
        strb.istat  = bus_wen && (bus_addr == ADDR_W'(OFF_ISTAT));
        strb.ienb   = bus_wen && (bus_addr == ADDR_W'(OFF_IENB));
        strb.cwstat = bus_wen && (bus_addr == ADDR_W'(OFF_CWSTAT));
        strb.gwstat = bus_wen && (bus_addr == ADDR_W'(OFF_GWSTAT));
    end

    assign wbits = '{b16: bus_wdata[GWS_CTRL], b8: bus_wdata[BIT_RUN],
                     b2: bus_wdata[GWS_INCR], b1: bus_wdata[BIT_AUTO_INC],
                     b0: bus_wdata[BIT_CMP_EN]};

    glb_timer_counter #(.DATA_W(DATA_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ld_lo (strb.cnt_lo),
        .ld_hi (strb.cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    glb_timer_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp_en   (cmp_en),
        .auto_inc (auto_inc),
        .wr_lo    (strb.cmp_lo),
        .wr_hi    (strb.cmp_hi),
        .wr_incr  (strb.incr),
        .wdata    (bus_wdata),
        .cmp      (cmp),
        .incr     (incr),
        .match    (match)
    );

    glb_timer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .wbits    (wbits),
        .match    (match),
        .run      (run),
        .cmp_en   (cmp_en),
        .auto_inc (auto_inc),
        .istat    (istat),
        .ien      (ien),
        .cws      (cws),
        .gws      (gws),
        .irq      (irq)
    );

    // Live read mux, no snapshot of the counter
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CNT_LO): bus_rdata = cnt[DATA_W-1:0];
            ADDR_W'(OFF_CNT_HI): bus_rdata = cnt[CNT_W-1:DATA_W];
            ADDR_W'(OFF_CMP_LO): bus_rdata = cmp[DATA_W-1:0];
            ADDR_W'(OFF_CMP_HI): bus_rdata = cmp[CNT_W-1:DATA_W];
            ADDR_W'(OFF_INCR):   bus_rdata = incr;
            ADDR_W'(OFF_CTRL): begin
                bus_rdata[BIT_RUN]      = run;
                bus_rdata[BIT_AUTO_INC] = auto_inc;
                bus_rdata[BIT_CMP_EN]   = cmp_en;
            end
            ADDR_W'(OFF_ISTAT):  bus_rdata[0] = istat;
            ADDR_W'(OFF_IENB):   bus_rdata[0] = ien;
            ADDR_W'(OFF_CWSTAT): bus_rdata[1:0] = cws;
            ADDR_W'(OFF_GWSTAT): begin
                bus_rdata[GWS_CMP_LO] = gws[0];
                bus_rdata[GWS_CMP_HI] = gws[1];
                bus_rdata[GWS_INCR]   = gws[2];
                bus_rdata[GWS_CTRL]   = gws[3];
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/glb_timer_chk.sv
module glb_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                run,
    input logic                cmp_en,
    input logic                auto_inc,
    input logic                match,
    input logic                istat,
    input logic                ien,
    input logic [1:0]          cws,
    input logic [3:0]          gws,
    input logic [2*DATA_W-1:0] cnt,
    input logic [2*DATA_W-1:0] cmp,
    input logic [DATA_W-1:0]   incr,
    input logic                wr_cnt,
    input logic                wr_cnt_lo,
    input logic                wr_cmp,
    input logic                wr_ctrl
);
    localparam int CNT_W = 2 * DATA_W;

    // R2: a running counter advances by one when not loaded
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2: a stopped counter holds when not loaded
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    // R5: an enabled equality raises the status bit next cycle
    assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (cnt == cmp)) |=> istat);

    // R5: the status bit only rises after a match
    assert_status_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat) |-> $past(match));

    // R6: the interrupt requires the enable bit
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && istat));

    // R8: periodic re-arm adds the increment
    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_inc && !wr_cmp) |=>
            (cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(incr)}));

    // R12: one-shot match keeps the compare value
    assert_oneshot_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !auto_inc && !wr_cmp) |=> $stable(cmp));

    // R9: a low-word counter write is confirmed
    assert_cnt_wstat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> cws[0]);

    // R10: a control write is confirmed
    assert_ctrl_wstat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> gws[3]);

endmodule

bind glb_timer_top glb_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .run       (run),
    .cmp_en    (cmp_en),
    .auto_inc  (auto_inc),
    .match     (match),
    .istat     (istat),
    .ien       (ien),
    .cws       (cws),
    .gws       (gws),
    .cnt       (cnt),
    .cmp       (cmp),
    .incr      (incr),
    .wr_cnt    (strb.cnt_lo || strb.cnt_hi),
    .wr_cnt_lo (strb.cnt_lo),
    .wr_cmp    (strb.cmp_lo || strb.cmp_hi),
    .wr_ctrl   (strb.ctrl)
);

// File: tb/glb_timer_top_tb.sv
module glb_timer_top_tb;

    localparam logic [11:0] A_CNT_LO = 12'h100, A_CNT_HI = 12'h104, A_CWS  = 12'h110;
    localparam logic [11:0] A_CMP_LO = 12'h200, A_CMP_HI = 12'h204, A_INCR = 12'h208;
    localparam logic [11:0] A_CTRL   = 12'h240, A_ISTAT  = 12'h244, A_IEN  = 12'h248;
    localparam logic [11:0] A_GWS    = 12'h24C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    glb_timer_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Scoreboard queues
    logic [11:0] addr_q[$];
    logic [31:0] exp_q[$];
    bit          isirq_q[$];
    string       tag_q[$];
    event        ev_sample;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    // Monitor: pops one expected item per sample event
    initial begin
        forever begin
            @(ev_sample);
            while (exp_q.size() > 0) begin
                logic [11:0] a;
                logic [31:0] e, act;
                bit          ii;
                string       t;
                a = addr_q.pop_front();
                e = exp_q.pop_front();
                ii = isirq_q.pop_front();
                t = tag_q.pop_front();
                act = ii ? {31'b0, irq} : bus_rdata;
                n_vec++;
                if (act !== e) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, act, e);
                end
            end
        end
    end

    // Driver tasks: called at a falling edge, return at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        #1;
        addr_q.push_back(a); exp_q.push_back(e); isirq_q.push_back(1'b0); tag_q.push_back(t);
        -> ev_sample;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string t);
        #1;
        addr_q.push_back(12'h0); exp_q.push_back({31'b0, e}); isirq_q.push_back(1'b1);
        tag_q.push_back(t);
        -> ev_sample;
        #1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(A_CNT_LO, 32'h0, "R1 cnt lo");
        expect_rd(A_CNT_HI, 32'h0, "R1 cnt hi");
        expect_rd(A_CMP_LO, 32'h0, "R1 cmp lo");
        expect_rd(A_INCR,   32'h0, "R1 incr");
        expect_rd(A_CTRL,   32'h0, "R1 ctrl");
        expect_rd(A_ISTAT,  32'h0, "R1 istat");
        expect_rd(A_IEN,    32'h0, "R1 ien");
        expect_rd(A_CWS,    32'h0, "R1 cwstat");
        expect_rd(A_GWS,    32'h0, "R1 gwstat");
        expect_irq(1'b0, "R1 irq");

        // R11 control readback mask
        wr(A_CTRL, 32'hFFFF_FFFF);
        expect_rd(A_CTRL, 32'h0000_0103, "R11 ctrl mask");
        wr(A_CTRL, 32'h0);
        wr(A_ISTAT, 32'h1);
        expect_rd(A_ISTAT, 32'h0, "R7 clear after stray match");
        wr(A_GWS, 32'h0001_0007);
        expect_rd(A_GWS, 32'h0, "R10 w1c all");

        // R9 / R3 loads with the counter stopped
        wr(A_CNT_LO, 32'hFFFF_FFFE);
        expect_rd(A_CWS, 32'h1, "R9 low write status");
        wr(A_CWS, 32'h1);
        expect_rd(A_CWS, 32'h0, "R9 low w1c");
        wr(A_CNT_HI, 32'h5);
        expect_rd(A_CWS, 32'h2, "R9 high write status");
        expect_rd(A_CNT_LO, 32'hFFFF_FFFE, "R3 low kept");
        expect_rd(A_CNT_HI, 32'h5, "R3 high loaded");
        tick(3);
        expect_rd(A_CNT_LO, 32'hFFFF_FFFE, "R2 hold when stopped");
        wr(A_CWS, 32'h2);
        expect_rd(A_CWS, 32'h0, "R9 high w1c");

        // R2 / R4 counting with carry
        wr(A_CTRL, 32'h100);
        tick(3);
        expect_rd(A_CNT_LO, 32'h1, "R4 carry low");
        expect_rd(A_CNT_HI, 32'h6, "R4 carry high");
        tick(2);
        expect_rd(A_CNT_LO, 32'h3, "R2 count step");

        // R3 load while running
        wr(A_CNT_LO, 32'h1000);
        tick(4);
        expect_rd(A_CNT_LO, 32'h1004, "R3 resume from load");
        expect_rd(A_CNT_HI, 32'h6, "R3 high untouched");

        // One-shot match
        wr(A_CTRL, 32'h0);
        wr(A_CNT_HI, 32'h0);
        wr(A_CNT_LO, 32'h0);
        wr(A_GWS, 32'h0001_0000);
        wr(A_CMP_LO, 32'd10);
        wr(A_CMP_HI, 32'h0);
        wr(A_IEN, 32'h1);
        expect_rd(A_GWS, 32'h3, "R10 compare write status");
        wr(A_GWS, 32'h3);
        wr(A_CTRL, 32'h101);
        tick(10);
        expect_rd(A_CNT_LO, 32'd10, "R5 counter at compare");
        expect_rd(A_ISTAT, 32'h0, "R5 not yet set");
        expect_irq(1'b0, "R6 irq low before match");
        tick(1);
        expect_rd(A_ISTAT, 32'h1, "R5 match status");
        expect_irq(1'b1, "R6 irq on match");
        expect_rd(A_CMP_LO, 32'd10, "R12 compare kept");
        wr(A_IEN, 32'h0);
        expect_irq(1'b0, "R6 irq gated off");
        expect_rd(A_ISTAT, 32'h1, "R6 status survives gating");
        wr(A_IEN, 32'h1);
        expect_irq(1'b1, "R6 irq gated on");
        wr(A_ISTAT, 32'h0);
        expect_rd(A_ISTAT, 32'h1, "R7 write zero no effect");
        wr(A_ISTAT, 32'h1);
        expect_rd(A_ISTAT, 32'h0, "R7 w1c");
        tick(5);
        expect_rd(A_ISTAT, 32'h0, "R12 no second match");
        expect_irq(1'b0, "R12 irq stays low");

        // Periodic match
        wr(A_CTRL, 32'h0);
        wr(A_CNT_LO, 32'h0);
        wr(A_CMP_LO, 32'd10);
        wr(A_INCR, 32'd5);
        expect_rd(A_GWS, 32'h0001_0005, "R10 ctrl/cmp/incr status");
        wr(A_GWS, 32'h0001_0005);
        expect_rd(A_GWS, 32'h0, "R10 cleared");
        wr(A_CTRL, 32'h103);
        tick(10);
        expect_rd(A_ISTAT, 32'h0, "R8 before first match");
        tick(1);
        expect_rd(A_ISTAT, 32'h1, "R8 first match");
        expect_rd(A_CMP_LO, 32'd15, "R8 compare advanced");
        wr(A_ISTAT, 32'h1);
        tick(3);
        expect_rd(A_ISTAT, 32'h0, "R8 before second match");
        tick(1);
        expect_rd(A_ISTAT, 32'h1, "R8 second match");
        expect_rd(A_CMP_LO, 32'd20, "R8 compare advanced again");

        // Set wins over clear, and disabled equality
        wr(A_CTRL, 32'h0);
        wr(A_ISTAT, 32'h1);
        wr(A_CNT_LO, 32'd100);
        wr(A_CMP_LO, 32'd100);
        wr(A_INCR, 32'd1);
        wr(A_CTRL, 32'h103);
        tick(1);
        expect_rd(A_ISTAT, 32'h1, "R8 lockstep match");
        wr(A_ISTAT, 32'h1);
        expect_rd(A_ISTAT, 32'h1, "R7 set wins over clear");
        expect_rd(A_CMP_LO, 32'd102, "R8 lockstep compare");
        wr(A_CTRL, 32'h0);
        wr(A_ISTAT, 32'h1);
        expect_rd(A_CNT_LO, 32'd103, "R5 counter equal");
        expect_rd(A_CMP_LO, 32'd103, "R5 compare equal");
        tick(3);
        expect_rd(A_ISTAT, 32'h0, "R5 disabled equality ignored");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule